// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A divider counts enable pulses from a 32,768 Hz reference and emits a one-cycle pulse once per second. That pulse advances a chain of counters: second, minute, hour (24-hour form), weekday, day of month, month, year and century. Each counter carries into the next when it wraps.

The eight counters form the lowest eight bytes of a byte-wide register map, so a bus front end can reach them. A write port loads any one byte on the next clock edge. A write to the seconds byte also restarts the sub-second divider, so the next advance comes one full second after the write. A combinational read port returns the byte selected by the read address. Month lengths follow the calendar, and February gets a 29th day in every year whose BCD value is a multiple of four.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the map reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, century 0x20, and no tick has been issued.
- R2: `tick_o` pulses for one cycle on every PRESCALE-th `ref_en` pulse. On that edge the seconds byte takes one BCD step, so 0x09 becomes 0x10.
- R3: Seconds and minutes go from 0x59 to 0x00 and carry into the next counter. Hours go from 0x23 to 0x00 and carry into both weekday and date.
- R4: The weekday counts 0x01 to 0x07, and the next day after 0x07 is 0x01.
- R5: The date returns to 0x01 and carries into the month after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other non-February months.
- R6: In February the date wraps after 0x28, or after 0x29 when the year byte read as a decimal number is divisible by four (0x00 counts as leap).
- R7: The month goes from 0x12 to 0x01 and carries into the year. On the same edge the year goes from 0x99 to 0x00 and the century takes one BCD step.
- R8: With `wr_en` high, `wr_data` is stored at the next edge in the byte at `wr_addr`. The addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century.
- R9: A write to address 0 clears the divider and suppresses any tick in that cycle. The next tick follows after PRESCALE further `ref_en` pulses.
- R10: When a write falls in a tick cycle, the written byte takes the written value and every other byte advances as usual.
- R11: `rd_data` always shows the byte at `rd_addr` with no clock delay.
- R12: In a cycle with neither a tick nor a write, no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | One-cycle enable at the 32,768 Hz reference rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Byte address of the write |
| wr_data | input | 8 | BCD byte to store |
| rd_addr | input | 3 | Byte address of the read |
| rd_data | output | 8 | BCD byte at `rd_addr` |
| tick_o | output | 1 | One-second advance pulse |

## Verification
The hardest cases to reach are the carry cascades, where a single second ends a month, a leap February or a century. Counting real seconds up to those points would be far too slow. The bench therefore preloads every byte through the write port to one second before the boundary, with the seconds byte written last so that the divider restarts, and then supplies exactly one second of reference pulses with a small PRESCALE. A second hard case is a write landing in the very cycle of a tick. The bench brings this about by aligning the write strobe with the final reference pulse of a second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

    // byte addresses of the counters; the field order below matches them
    typedef enum logic [ADDR_W-1:0] {
        REG_SEC   = 3'd0,
        REG_MIN   = 3'd1,
        REG_HOUR  = 3'd2,
        REG_WDAY  = 3'd3,
        REG_DATE  = 3'd4,
        REG_MONTH = 3'd5,
        REG_YEAR  = 3'd6,
        REG_CENT  = 3'd7
    } rtc_reg_e;

    // last member is the least significant byte, so byte lane i is address i
    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{
        cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
        wday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    // one decimal step of a two-digit BCD byte (range checks done by caller)
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    assign wrap = ref_en && (st_q.cnt == LAST);
    assign tick = wrap && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (ref_en) begin
            if (wrap) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    assign year_bin = bcd_to_bin(year);
    assign leap     = (year_bin[1:0] == 2'b00);

    always_comb begin
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            last_date,
    output rtc_time_t             cal_o
);
    rtc_time_t cal_d, cal_q;
    rtc_time_t adv;
    logic [NUM_REGS-1:0][7:0] lanes;

    assign cal_o = cal_q;

    // carry chain for one second
    always_comb begin
        logic c_min, c_hour, c_day, c_mon, c_year;
        adv    = cal_q;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;

        if (cal_q.sec >= 8'h59) begin
            adv.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            adv.sec = bcd_step(cal_q.sec);
        end

        if (c_min) begin
            if (cal_q.min >= 8'h59) begin
                adv.min = 8'h00;
                c_hour  = 1'b1;
            end else begin
                adv.min = bcd_step(cal_q.min);
            end
        end

        if (c_hour) begin
            if (cal_q.hour >= 8'h23) begin
                adv.hour = 8'h00;
                c_day    = 1'b1;
            end else begin
                adv.hour = bcd_step(cal_q.hour);
            end
        end

        if (c_day) begin
            if (cal_q.wday >= 8'h07) adv.wday = 8'h01;
            else                     adv.wday = bcd_step(cal_q.wday);

            if (cal_q.date >= last_date) begin
                adv.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                adv.date = bcd_step(cal_q.date);
            end
        end

        if (c_mon) begin
            if (cal_q.month >= 8'h12) begin
                adv.month = 8'h01;
                c_year    = 1'b1;
            end else begin
                adv.month = bcd_step(cal_q.month);
            end
        end

        if (c_year) begin
            if (cal_q.year >= 8'h99) begin
                adv.year = 8'h00;
                if (cal_q.cent >= 8'h99) adv.cent = 8'h00;
                else                     adv.cent = bcd_step(cal_q.cent);
            end else begin
                adv.year = bcd_step(cal_q.year);
            end
        end
    end

    // next state: advanced value, then the written lane overrides
    always_comb begin
        lanes = tick ? adv : cal_q;
        if (wr_en) lanes[wr_addr] = wr_data;
        cal_d = rtc_time_t'(lanes);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= RTC_RESET;
        else        cal_q <= cal_d;
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              tick_o
);
    logic      sec_clr;
    logic      tick;
    logic [7:0] last_date;
    rtc_time_t cal_q;
    logic [NUM_REGS-1:0][7:0] rd_lanes;

    assign sec_clr = wr_en && (wr_addr == REG_SEC);

    rtc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .clr    (sec_clr),
        .tick   (tick)
    );

    rtc_month_len u_mlen (
        .month     (cal_q.month),
        .year      (cal_q.year),
        .last_date (last_date)
    );

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .last_date (last_date),
        .cal_o     (cal_q)
    );

    assign rd_lanes = cal_q;
    assign rd_data  = rd_lanes[rd_addr];
    assign tick_o   = tick;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input rtc_time_t         cal
);
    // R2
    sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (cal.sec != $past(cal.sec)));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cal.sec == 8'h59) |=>
            (cal.sec == 8'h00 && cal.min != $past(cal.min)));

    // R7
    century_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cal.year == 8'h99 && cal.month == 8'h12 &&
         cal.date == 8'h31 && cal.hour == 8'h23 && cal.min == 8'h59 &&
         cal.sec == 8'h59) |=>
            (cal.year == 8'h00 && cal.cent != $past(cal.cent)));

    // R8
    sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SEC) |=> (cal.sec == $past(wr_data)));

    // R9
    clr_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SEC) |-> !tick);

    // R10
    tick_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wr_en && wr_addr == REG_MIN) |=>
            (cal.min == $past(wr_data) && cal.sec != $past(cal.sec)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cal));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cal     (cal_q)
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
    localparam int PS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick_o;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bcd_rtc_core #(.PRESCALE(PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick_o(tick_o)
    );

    always @(posedge clk) if (rst_n && tick_o) tick_cnt <= tick_cnt + 1;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a,
                              input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, $sformatf("addr%0d", a), v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ref_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_en = 1'b1;
            @(negedge clk); ref_en = 1'b0;
        end
    endtask

    // seconds written last so the divider restarts
    task automatic set_time(input logic [7:0] cent, year, month, date,
                            wday, hour, min, sec);
        wr(7, cent); wr(6, year); wr(5, month); wr(4, date);
        wr(3, wday); wr(2, hour); wr(1, min); wr(0, sec);
    endtask

    task automatic t_reset;
        expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
        expect_reg("R1", 2, 8'h00); expect_reg("R1", 3, 8'h01);
        expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
        expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h20);
        check("R1", "ticks", 8'(tick_cnt), 8'd0);
    endtask

    task automatic t_tick;
        ref_pulse(PS - 1);
        expect_reg("R2", 0, 8'h00);
        check("R2", "ticks before", 8'(tick_cnt), 8'd0);
        ref_pulse(1);
        expect_reg("R2", 0, 8'h01);
        check("R2", "ticks after", 8'(tick_cnt), 8'd1);
        repeat (10) @(negedge clk);
        expect_reg("R12", 0, 8'h01);
        set_time(8'h20, 8'h11, 8'h03, 8'h05, 8'h02, 8'h10, 8'h20, 8'h09);
        ref_pulse(PS);
        expect_reg("R2", 0, 8'h10);
        expect_reg("R12", 1, 8'h20);
    endtask

    task automatic t_write_read;
        set_time(8'h19, 8'h87, 8'h06, 8'h14, 8'h05, 8'h13, 8'h42, 8'h37);
        expect_reg("R8", 7, 8'h19); expect_reg("R8", 6, 8'h87);
        expect_reg("R8", 5, 8'h06); expect_reg("R8", 4, 8'h14);
        expect_reg("R11", 3, 8'h05); expect_reg("R11", 2, 8'h13);
        expect_reg("R11", 1, 8'h42); expect_reg("R8", 0, 8'h37);
    endtask

    task automatic t_day_rollover;
        set_time(8'h20, 8'h23, 8'h05, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R3", 0, 8'h00); expect_reg("R3", 1, 8'h00);
        expect_reg("R3", 2, 8'h00); expect_reg("R4", 3, 8'h01);
        expect_reg("R3", 4, 8'h16); expect_reg("R3", 5, 8'h05);
        set_time(8'h20, 8'h23, 8'h05, 8'h15, 8'h03, 8'h08, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R3", 2, 8'h09); expect_reg("R3", 3, 8'h03);
    endtask

    task automatic t_month_len;
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R5", 4, 8'h01); expect_reg("R5", 5, 8'h05);
        set_time(8'h20, 8'h23, 8'h07, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R5", 4, 8'h31); expect_reg("R5", 5, 8'h07);
        ref_pulse(PS * 86400 / 86400);
        set_time(8'h20, 8'h23, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R5", 4, 8'h01); expect_reg("R5", 5, 8'h12);
    endtask

    task automatic t_february;
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h03);
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R6", 4, 8'h29); expect_reg("R6", 5, 8'h02);
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h03);
        set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R6", 4, 8'h29);
        set_time(8'h20, 8'h18, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R6", 4, 8'h01);
    endtask

    task automatic t_year_century;
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R7", 6, 8'h00); expect_reg("R7", 7, 8'h21);
        expect_reg("R7", 5, 8'h01); expect_reg("R7", 4, 8'h01);
        set_time(8'h20, 8'h49, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        ref_pulse(PS);
        expect_reg("R7", 6, 8'h50); expect_reg("R7", 7, 8'h20);
    endtask

    task automatic t_prescaler_clear;
        int t0;
        set_time(8'h20, 8'h30, 8'h08, 8'h08, 8'h04, 8'h08, 8'h08, 8'h10);
        ref_pulse(PS - 1);
        wr(0, 8'h30);
        t0 = tick_cnt;
        ref_pulse(PS - 1);
        expect_reg("R9", 0, 8'h30);
        check("R9", "no tick yet", 8'(tick_cnt - t0), 8'd0);
        ref_pulse(1);
        expect_reg("R9", 0, 8'h31);
    endtask

    task automatic t_write_on_tick;
        set_time(8'h20, 8'h30, 8'h08, 8'h08, 8'h04, 8'h08, 8'h05, 8'h20);
        ref_pulse(PS - 1);
        @(negedge clk);
        ref_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h40;
        @(negedge clk);
        ref_en = 1'b0; wr_en = 1'b0;
        expect_reg("R10", 1, 8'h40);
        expect_reg("R10", 0, 8'h21);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick();
        t_write_read();
        t_day_rollover();
        t_month_len();
        t_february();
        t_year_century();
        t_prescaler_clear();
        t_write_on_tick();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule